// File: doc/BRIEF.md
# Dual-Rate Clock-Enable Prescaler

This block turns the system clock into two streams of single-cycle enable pulses, one pacing a capture/compare timer counter and one pacing a PWM counter. A free-running nine-stage binary divider makes power-of-two strobes. Each consumer has its own three-bit rate field, which picks one of seven adjacent divider strobes or a cleaned-up external clock. The external pin is first brought into the clock domain by a two-stage synchronizer. A digital filter then rejects short glitches on it, and each accepted rising edge produces one pulse.

The two rate fields are loaded through plain write strobes. The PWM field can be changed freely. The timer field takes only the first write after reset, unless the test or freeze input is high while the write happens. A status pin shows whether the timer field has been locked. The outputs are enables for logic that runs on the system clock, not derived clocks.

Top module: `dual_rate_prescaler`

## Requirements
- R1: After reset the timer enable pulses every 4 system clocks, the PWM enable pulses every 2 system clocks, and the lock status reads 0.
- R2: Timer field codes 0 to 6 give a timer enable period of 4, 8, 16, 32, 64, 128 and 256 clocks respectively (period = 4 << code).
- R3: PWM field codes 0 to 6 give a PWM enable period of 2, 4, 8, 16, 32, 64 and 128 clocks respectively (period = 2 << code).
- R4: Every enable pulse is exactly one system clock wide, and a divider-driven enable repeats at exactly its selected period.
- R5: Code 7 in either field selects the filtered external input, and that enable then pulses exactly once for each accepted rising edge of the pin.
- R6: The pin filter accepts a new level only after it has been seen for three consecutive clocks. High pulses of 1 or 2 clocks produce no enable, a 3-clock high pulse produces one, and low glitches of 2 clocks during a long high produce no extra enable.
- R7: The first timer-field write after reset is applied and sets the lock status to 1. While locked, with test and freeze both low, a later timer write leaves the timer period unchanged.
- R8: While test or freeze is high, every timer-field write is applied, whether or not the field is locked.
- R9: PWM-field writes are applied at any time, including while the timer field is locked and test and freeze are low.
- R10: Reset clears the lock status and returns the timer field to its default (period 4), so the next write is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous to clk_i |
| test_mode_i | input | 1 | Test mode; unlocks timer-field writes |
| freeze_i | input | 1 | Freeze mode; unlocks timer-field writes |
| tmr_we_i | input | 1 | Write strobe for the timer rate field |
| tmr_wdata_i | input | 3 | Timer rate code (0-6 divider, 7 external) |
| pwm_we_i | input | 1 | Write strobe for the PWM rate field |
| pwm_wdata_i | input | 3 | PWM rate code (0-6 divider, 7 external) |
| tmr_tick_o | output | 1 | Single-cycle enable for the timer counter |
| pwm_tick_o | output | 1 | Single-cycle enable for the PWM counter |
| tmr_locked_o | output | 1 | High once the timer field has taken its first write |

## Verification
The embedded properties assume that the write strobes, write data and mode inputs carry known values at every clock edge, and that a write strobe is sampled as one cycle per write. They make no assumption about when the external pin moves. The filter properties therefore hold for any pin waveform. The bench changes every input on the falling clock edge and holds each write strobe for exactly one cycle. It waits out one enable after every rate change before it measures a period, so no check depends on the phase in which a new rate takes effect.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  // Default configuration shared by the prescaler modules.
  localparam int unsigned DEF_DIV_STAGES = 9;  // binary divider depth
  localparam int unsigned DEF_SEL_W      = 3;  // rate field width
  localparam int unsigned DEF_SYNC_STAGES = 2; // pin synchronizer depth
  localparam int unsigned DEF_FILT_LEN   = 3;  // stable clocks before a pin level is accepted
  localparam int unsigned DEF_TMR_LOW_TAP = 2; // timer code 0 -> divide by 2**2
  localparam int unsigned DEF_PWM_LOW_TAP = 1; // PWM code 0 -> divide by 2**1

  // Which consumer a rate field paces.
  typedef enum logic {
    CONSUMER_TIMER = 1'b0,
    CONSUMER_PWM   = 1'b1
  } consumer_e;
endpackage

// File: rtl/pre_divider.sv
module pre_divider #(
  parameter int unsigned STAGES = prescaler_pkg::DEF_DIV_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [STAGES:1]   taps_o   // taps_o[k]: one-cycle strobe every 2**k clocks
);
  logic [STAGES-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    logic tap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q <= 1'b0;
      else         tap_q <= &cnt_q[k-1:0];
    end
    assign taps_o[k] = tap_q;

    if (k >= 2) begin : g_nest
      // A slower strobe always coincides with every faster one (R4).
      p_tap_nested_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taps_o[k] |-> taps_o[k-1]);
    end
  end

  // The fastest strobe never lasts two cycles (R4).
  p_tap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taps_o[1] |=> !taps_o[1]);
endmodule

// File: rtl/pin_filter.sv
module pin_filter #(
  parameter int unsigned SYNC_STAGES = prescaler_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = prescaler_pkg::DEF_FILT_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o   // one cycle per accepted rising edge
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   level_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign smp = sync_q[SYNC_STAGES-1];

  // Count consecutive samples that disagree with the accepted level.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (smp == level_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      run_q   <= '0;
      level_q <= smp;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_d_q <= 1'b0;
    else         level_d_q <= level_q;
  end

  assign rise_o = level_q & ~level_d_q;

  // The accepted level only ever moves toward the synchronized sample (R6).
  p_level_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_q) |-> ($past(smp) == level_q));
  // An accepted edge yields a one-cycle strobe (R5).
  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tap_select.sv
module tap_select #(
  parameter int unsigned STAGES  = prescaler_pkg::DEF_DIV_STAGES,
  parameter int unsigned SEL_W   = prescaler_pkg::DEF_SEL_W,
  parameter int unsigned LOW_TAP = prescaler_pkg::DEF_TMR_LOW_TAP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STAGES:1]  taps_i,
  input  logic             ext_rise_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam logic [SEL_W-1:0] EXT_CODE = {SEL_W{1'b1}};
  localparam int unsigned      IDX_W    = $clog2(STAGES + 1);

  logic [IDX_W-1:0] idx;
  logic             pick;

  assign idx  = IDX_W'(LOW_TAP) + IDX_W'(sel_i);
  assign pick = (sel_i == EXT_CODE) ? ext_rise_i : taps_i[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= pick;
  end

  // With the external path chosen, every enable traces to a filtered edge (R5).
  p_ext_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(sel_i) == EXT_CODE) |-> $past(ext_rise_i));
  // A divider-driven enable is never two cycles wide (R4).
  p_tap_no_b2b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sel_i) != EXT_CODE && tick_o) |=> !tick_o);
endmodule

// File: rtl/rate_cfg.sv
module rate_cfg #(
  parameter int unsigned     SEL_W   = prescaler_pkg::DEF_SEL_W,
  parameter logic [SEL_W-1:0] TMR_RST = '0,
  parameter logic [SEL_W-1:0] PWM_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             test_mode_i,
  input  logic             freeze_i,
  input  logic             tmr_we_i,
  input  logic [SEL_W-1:0] tmr_wdata_i,
  input  logic             pwm_we_i,
  input  logic [SEL_W-1:0] pwm_wdata_i,
  output logic [SEL_W-1:0] tmr_sel_o,
  output logic [SEL_W-1:0] pwm_sel_o,
  output logic             locked_o
);
  logic tmr_open;
  assign tmr_open = ~locked_o | test_mode_i | freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_sel_o <= TMR_RST;
      locked_o  <= 1'b0;
    end else if (tmr_we_i) begin
      locked_o <= 1'b1;
      if (tmr_open) tmr_sel_o <= tmr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pwm_sel_o <= PWM_RST;
    else if (pwm_we_i) pwm_sel_o <= pwm_wdata_i;
  end

  p_lock_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_we_i |=> locked_o);
  p_locked_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && tmr_we_i && !test_mode_i && !freeze_i) |=> $stable(tmr_sel_o));
  p_mode_unlock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_we_i && (test_mode_i || freeze_i)) |=> (tmr_sel_o == $past(tmr_wdata_i)));
  p_pwm_any_time_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_we_i |=> (pwm_sel_o == $past(pwm_wdata_i)));
endmodule

// File: rtl/dual_rate_prescaler.sv
module dual_rate_prescaler #(
  parameter int unsigned DIV_STAGES  = prescaler_pkg::DEF_DIV_STAGES,
  parameter int unsigned SEL_W       = prescaler_pkg::DEF_SEL_W,
  parameter int unsigned SYNC_STAGES = prescaler_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = prescaler_pkg::DEF_FILT_LEN,
  parameter int unsigned TMR_LOW_TAP = prescaler_pkg::DEF_TMR_LOW_TAP,
  parameter int unsigned PWM_LOW_TAP = prescaler_pkg::DEF_PWM_LOW_TAP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             test_mode_i,
  input  logic             freeze_i,
  input  logic             tmr_we_i,
  input  logic [SEL_W-1:0] tmr_wdata_i,
  input  logic             pwm_we_i,
  input  logic [SEL_W-1:0] pwm_wdata_i,
  output logic             tmr_tick_o,
  output logic             pwm_tick_o,
  output logic             tmr_locked_o
);
  localparam int unsigned N_CODES = 1 << SEL_W;
  localparam int unsigned TOP_TAP_T = TMR_LOW_TAP + N_CODES - 2;
  localparam int unsigned TOP_TAP_P = PWM_LOW_TAP + N_CODES - 2;

  logic [DIV_STAGES:1] taps;
  logic                ext_rise;
  logic [SEL_W-1:0]    tmr_sel;
  logic [SEL_W-1:0]    pwm_sel;

  pre_divider #(.STAGES(DIV_STAGES)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .taps_o (taps)
  );

  pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_clk_i),
    .rise_o (ext_rise)
  );

  rate_cfg #(.SEL_W(SEL_W), .TMR_RST('0), .PWM_RST('0)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_mode_i (test_mode_i),
    .freeze_i    (freeze_i),
    .tmr_we_i    (tmr_we_i),
    .tmr_wdata_i (tmr_wdata_i),
    .pwm_we_i    (pwm_we_i),
    .pwm_wdata_i (pwm_wdata_i),
    .tmr_sel_o   (tmr_sel),
    .pwm_sel_o   (pwm_sel),
    .locked_o    (tmr_locked_o)
  );

  tap_select #(.STAGES(DIV_STAGES), .SEL_W(SEL_W), .LOW_TAP(TMR_LOW_TAP)) u_tmr_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .taps_i     (taps),
    .ext_rise_i (ext_rise),
    .sel_i      (tmr_sel),
    .tick_o     (tmr_tick_o)
  );

  tap_select #(.STAGES(DIV_STAGES), .SEL_W(SEL_W), .LOW_TAP(PWM_LOW_TAP)) u_pwm_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .taps_i     (taps),
    .ext_rise_i (ext_rise),
    .sel_i      (pwm_sel),
    .tick_o     (pwm_tick_o)
  );

  // Both selectors must stay within the divider depth.
  initial begin
    p_taps_fit_r2: assert (TOP_TAP_T <= DIV_STAGES && TMR_LOW_TAP >= 1);
    p_taps_fit_r3: assert (TOP_TAP_P <= DIV_STAGES && PWM_LOW_TAP >= 1);
  end

  // Right after reset neither field is locked (R1, R10).
  p_reset_unlocked_r10: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !tmr_locked_o);
endmodule

// File: tb/tb_dual_rate_prescaler.sv
module tb_dual_rate_prescaler;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni, ext_clk_i, test_mode_i, freeze_i, tmr_we_i, pwm_we_i;
  logic [2:0] tmr_wdata_i, pwm_wdata_i;
  logic       tmr_tick_o, pwm_tick_o, tmr_locked_o;

  int checks = 0;
  int failures = 0;
  int ct_g, cp_g;
  bit wide_g, pt_g, pp_g;

  dual_rate_prescaler dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i),
    .test_mode_i(test_mode_i), .freeze_i(freeze_i),
    .tmr_we_i(tmr_we_i), .tmr_wdata_i(tmr_wdata_i),
    .pwm_we_i(pwm_we_i), .pwm_wdata_i(pwm_wdata_i),
    .tmr_tick_o(tmr_tick_o), .pwm_tick_o(pwm_tick_o),
    .tmr_locked_o(tmr_locked_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tk(bit pwm);
    return pwm ? pwm_tick_o : tmr_tick_o;
  endfunction

  task automatic wait_tick(bit pwm);
    int c = 0;
    while (!tk(pwm) && c < 4000) begin
      @(negedge clk);
      c++;
    end
  endtask

  // Skip one enable after any change, then time the next interval.
  task automatic measure(bit pwm, output int per, output bit single);
    wait_tick(pwm);
    @(negedge clk);
    wait_tick(pwm);
    @(negedge clk);
    single = !tk(pwm);
    per = 1;
    while (!tk(pwm) && per < 4000) begin
      @(negedge clk);
      per++;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_tmr(int code);
    @(negedge clk);
    tmr_we_i = 1'b1; tmr_wdata_i = 3'(code);
    @(negedge clk);
    tmr_we_i = 1'b0;
  endtask

  task automatic wr_pwm(int code);
    @(negedge clk);
    pwm_we_i = 1'b1; pwm_wdata_i = 3'(code);
    @(negedge clk);
    pwm_we_i = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk);
    if (tmr_tick_o) ct_g++;
    if (pwm_tick_o) cp_g++;
    if ((tmr_tick_o && pt_g) || (pwm_tick_o && pp_g)) wide_g = 1'b1;
    pt_g = tmr_tick_o;
    pp_g = pwm_tick_o;
  endtask

  task automatic run_ext(int n, int hi, int lo);
    ct_g = 0; cp_g = 0; wide_g = 1'b0; pt_g = 1'b0; pp_g = 1'b0;
    for (int i = 0; i < n; i++) begin
      ext_clk_i = 1'b1;
      repeat (hi) sample();
      ext_clk_i = 1'b0;
      repeat (lo) sample();
    end
    repeat (12) sample();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int per;
    bit single;
    rst_ni = 1'b0; ext_clk_i = 1'b0; test_mode_i = 1'b0; freeze_i = 1'b0;
    tmr_we_i = 1'b0; pwm_we_i = 1'b0; tmr_wdata_i = '0; pwm_wdata_i = '0;
    do_reset();

    // R1: reset defaults
    check(tmr_locked_o == 1'b0, "R1 lock after reset", int'(tmr_locked_o), 0);
    measure(1'b0, per, single);
    check(per == 4, "R1 timer default period", per, 4);
    measure(1'b1, per, single);
    check(per == 2, "R1 pwm default period", per, 2);
    check(single, "R4 pwm default pulse width", int'(!single) + 1, 1);

    // R7: first write takes effect and locks; a later one is dropped
    wr_tmr(3);
    check(tmr_locked_o == 1'b1, "R7 lock after first write", int'(tmr_locked_o), 1);
    measure(1'b0, per, single);
    check(per == 32, "R7 first write applied", per, 32);
    wr_tmr(1);
    measure(1'b0, per, single);
    check(per == 32, "R7 locked write ignored", per, 32);

    // R8: freeze and test each reopen the timer field
    freeze_i = 1'b1;
    wr_tmr(1);
    freeze_i = 1'b0;
    measure(1'b0, per, single);
    check(per == 8, "R8 write under freeze", per, 8);
    test_mode_i = 1'b1;
    wr_tmr(5);
    test_mode_i = 1'b0;
    measure(1'b0, per, single);
    check(per == 128, "R8 write under test", per, 128);
    wr_tmr(0);
    measure(1'b0, per, single);
    check(per == 128, "R7 relocked write ignored", per, 128);

    // R3, R9: PWM sweep while the timer field is locked and modes are low
    for (int code = 0; code < 7; code++) begin
      wr_pwm(code);
      measure(1'b1, per, single);
      check(per == (2 << code), $sformatf("R3 R9 pwm code %0d", code), per, 2 << code);
      check(single, $sformatf("R4 pwm width code %0d", code), int'(!single) + 1, 1);
    end

    // R10: reset clears the lock and the timer field
    do_reset();
    check(tmr_locked_o == 1'b0, "R10 lock cleared", int'(tmr_locked_o), 0);
    measure(1'b0, per, single);
    check(per == 4, "R10 timer default restored", per, 4);
    wr_tmr(2);
    measure(1'b0, per, single);
    check(per == 16, "R10 write accepted after reset", per, 16);

    // R2: timer sweep with test mode held
    test_mode_i = 1'b1;
    for (int code = 0; code < 7; code++) begin
      wr_tmr(code);
      measure(1'b0, per, single);
      check(per == (4 << code), $sformatf("R2 timer code %0d", code), per, 4 << code);
      check(single, $sformatf("R4 timer width code %0d", code), int'(!single) + 1, 1);
    end

    // R5: external input on both consumers
    wr_tmr(7);
    wr_pwm(7);
    repeat (10) @(negedge clk);
    run_ext(10, 5, 5);
    check(ct_g == 10, "R5 timer ext edges", ct_g, 10);
    check(cp_g == 10, "R5 pwm ext edges", cp_g, 10);
    check(!wide_g, "R5 ext pulse width", int'(wide_g), 0);

    // R6: filter rejects short pulses, accepts three-clock ones
    run_ext(5, 1, 8);
    check(ct_g == 0, "R6 one-clock glitches", ct_g, 0);
    run_ext(5, 2, 8);
    check(cp_g == 0, "R6 two-clock glitches", cp_g, 0);
    run_ext(4, 3, 8);
    check(ct_g == 4, "R6 three-clock pulses timer", ct_g, 4);
    check(cp_g == 4, "R6 three-clock pulses pwm", cp_g, 4);
    run_ext(4, 10, 2);
    check(ct_g == 1, "R6 low glitches inside high", ct_g, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule